// File: doc/BRIEF.md
# MSI Vector Interrupt Aggregator

The block gathers message-signalled interrupts for a host controller. An interrupt arrives as a write of a vector number, either on a dedicated doorbell port or as a bus write to the doorbell register. The block records each vector in one of several small status groups. Consecutive vectors go to different groups: vector `v` lands in group `v mod 8`, and its bit inside that group is `v / 8`.

Each vector has its own enable bit. Each group drives one interrupt line, which is high while the group has a pending bit that is also enabled. After software services a group, it writes an end-of-interrupt code. The group's line then drops for one cycle and is evaluated again, so any bits still pending produce a fresh rising edge.

A small legacy section is included. It has four level-sampled interrupt lines, each with a sticky status bit, an enable bit and its own output. It shares the end-of-interrupt register with the message-signalled groups.

Top module: `msi_irq_agg`

## Requirements
- R1: A doorbell vector `v` below 32 sets bit `v >> 3` of group `v & 7`. Group `g` status reads back in bits [3:0] at address 0x104 + 0x10*g.
- R2: A bus write to address 0x054 acts as a doorbell, with the full write data taken as the vector number. The `db_valid`/`db_vector` port behaves the same way.
- R3: A doorbell whose vector is 32 or greater leaves every status bit unchanged.
- R4: Writing 1 to a bit of a group status register clears it. Bits written with 0 keep their value.
- R5: Writing 1s to 0x108 + 0x10*g enables those vectors. Writing 1s to 0x10C + 0x10*g disables them. If the same bit is set and cleared in one cycle, the clear wins. Reading either address returns the group's enable mask.
- R6: `msi_irq[g]` is high in the cycle after any state change that makes (status & enable) of group g nonzero, and it stays high while that holds.
- R7: Writing g + 4 to the EOI register at 0x050 drives `msi_irq[g]` low for exactly one cycle. After that the line follows R6 again. Other groups are not affected.
- R8: If a doorbell and a write-1-to-clear hit the same status bit in one cycle, the bit ends up set.
- R9: A high `intx_in[n]` at a clock edge sets legacy status bit 0 at 0x184 + 0x10*n. Writing 1 clears it. Enable set and clear are at 0x188 and 0x18C + 0x10*n. `intx_irq[n]` equals status & enable.
- R10: Writing n (n < 4) to the EOI register drops `intx_irq[n]` for one cycle. EOI values of 12 or more have no effect.
- R11: After reset all status and enables are 0, every output is low, and reads of any address, mapped or not, return 0 except where a mapped register holds a nonzero value.
- R12: `reg_rdata` updates on the clock edge that samples `reg_rd_en` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| db_valid | input | 1 | Doorbell port strobe |
| db_vector | input | 32 | Doorbell vector number |
| intx_in | input | 4 | Legacy interrupt levels |
| msi_irq | output | 8 | Per-group interrupt lines |
| intx_irq | output | 4 | Per-line legacy interrupt outputs |

## Verification
A wrong group or bit mapping shows up immediately: the next status read of the expected group returns the wrong mask, and the wrong `msi_irq` line rises one cycle after the doorbell. Corrupted enable state appears on the interrupt lines in the very next cycle, and at the latest on the next read of either enable alias. EOI blanking faults are visible within two cycles of the EOI write, either as a missing low pulse or as a line that fails to return high while bits are still pending.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] ADDR_EOI      = 12'h050;
  localparam logic [REG_AW-1:0] ADDR_DOORBELL = 12'h054;

  localparam int MSI_BANK_BASE  = 'h100;
  localparam int INTX_BANK_BASE = 'h180;
  localparam int BANK_STRIDE    = 'h10;
  localparam int OFS_STAT       = 'h4;
  localparam int OFS_SET        = 'h8;
  localparam int OFS_CLR        = 'hC;

  // EOI code of the first message-signalled group
  localparam int EOI_MSI_FIRST = 4;

  typedef enum logic [1:0] {FLD_NONE, FLD_STAT, FLD_SET, FLD_CLR} fld_e;

  // group index of a vector: low bits (interleaved spreading)
  function automatic int vec_group(input logic [31:0] v, input int ngrp);
    return int'(v % 32'(ngrp));
  endfunction

  // bit position of a vector inside its group
  function automatic int vec_bit(input logic [31:0] v, input int ngrp);
    return int'(v / 32'(ngrp));
  endfunction

  function automatic logic vec_ok(input logic [31:0] v, input int nvec);
    return v < 32'(nvec);
  endfunction

  function automatic logic [REG_AW-1:0] bank_addr(input int base, input int idx,
                                                  input int ofs);
    return REG_AW'(base + idx * BANK_STRIDE + ofs);
  endfunction

  function automatic fld_e field_of(input logic [REG_AW-1:0] a, input int base,
                                    input int idx);
    if (a == bank_addr(base, idx, OFS_STAT)) return FLD_STAT;
    if (a == bank_addr(base, idx, OFS_SET))  return FLD_SET;
    if (a == bank_addr(base, idx, OFS_CLR))  return FLD_CLR;
    return FLD_NONE;
  endfunction

endpackage

// File: rtl/msi_group_slice.sv
module msi_group_slice #(
  parameter int BPG = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BPG-1:0] db_hit,
  input  logic [BPG-1:0] w1c,
  input  logic [BPG-1:0] en_set,
  input  logic [BPG-1:0] en_clr,
  input  logic           eoi_hit,
  output logic [BPG-1:0] stat_o,
  output logic [BPG-1:0] en_o,
  output logic           irq_o
);

  logic [BPG-1:0] stat_q, en_q;
  logic           blank_q;
  logic           pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      blank_q <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~w1c) | db_hit;
      en_q    <= (en_q | en_set) & ~en_clr;
      blank_q <= eoi_hit;
    end
  end

  assign pending = |(stat_q & en_q);
  assign irq_o   = pending & ~blank_q;
  assign stat_o  = stat_q;
  assign en_o    = en_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c & ~db_hit)) |=> ((stat_q & $past(w1c & ~db_hit)) == '0)); // R4

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_set & ~en_clr)) |=> ((en_q & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr))); // R5

  AST_EOI_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !irq_o); // R7

  AST_DOORBELL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(db_hit & w1c)) |=> ((stat_q & $past(db_hit & w1c)) == $past(db_hit & w1c))); // R8

endmodule

// File: rtl/intx_line_slice.sv
module intx_line_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic w1c,
  input  logic en_set,
  input  logic en_clr,
  input  logic eoi_hit,
  output logic stat_o,
  output logic en_o,
  output logic irq_o
);

  logic stat_q, en_q, blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      en_q    <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~w1c) | line_in;
      en_q    <= (en_q | en_set) & ~en_clr;
      blank_q <= eoi_hit;
    end
  end

  assign irq_o  = stat_q & en_q & ~blank_q;
  assign stat_o = stat_q;
  assign en_o   = en_q;

  AST_INTX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    line_in |=> stat_o); // R9

  AST_INTX_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !irq_o); // R10

endmodule

// File: rtl/msi_agg_regif.sv
module msi_agg_regif
  import msi_agg_pkg::*;
#(
  parameter int NG  = 8,
  parameter int BPG = 4,
  parameter int NL  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic                     reg_rd_en,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [REG_DW-1:0]        reg_wdata,
  input  logic [NG-1:0][BPG-1:0]   msi_stat,
  input  logic [NG-1:0][BPG-1:0]   msi_en,
  input  logic [NL-1:0]            intx_stat,
  input  logic [NL-1:0]            intx_en,
  output logic [NG-1:0][BPG-1:0]   msi_w1c,
  output logic [NG-1:0][BPG-1:0]   msi_set,
  output logic [NG-1:0][BPG-1:0]   msi_clr,
  output logic [NG-1:0]            msi_eoi,
  output logic [NL-1:0]            intx_w1c,
  output logic [NL-1:0]            intx_set,
  output logic [NL-1:0]            intx_clr,
  output logic [NL-1:0]            intx_eoi,
  output logic                     bus_db_valid,
  output logic [REG_DW-1:0]        bus_db_vec,
  output logic [REG_DW-1:0]        reg_rdata
);

  logic             eoi_wr;
  logic [REG_DW-1:0] rd_mux;

  assign eoi_wr       = reg_wr_en && (reg_addr == ADDR_EOI);
  assign bus_db_valid = reg_wr_en && (reg_addr == ADDR_DOORBELL);
  assign bus_db_vec   = reg_wdata;

  // write decode
  always_comb begin
    msi_w1c  = '0;
    msi_set  = '0;
    msi_clr  = '0;
    msi_eoi  = '0;
    intx_w1c = '0;
    intx_set = '0;
    intx_clr = '0;
    intx_eoi = '0;
    for (int g = 0; g < NG; g++) begin
      if (reg_wr_en) begin
        unique case (field_of(reg_addr, MSI_BANK_BASE, g))
          FLD_STAT: msi_w1c[g] = reg_wdata[BPG-1:0];
          FLD_SET:  msi_set[g] = reg_wdata[BPG-1:0];
          FLD_CLR:  msi_clr[g] = reg_wdata[BPG-1:0];
          default:  ;
        endcase
      end
      if (eoi_wr && reg_wdata == REG_DW'(EOI_MSI_FIRST + g)) msi_eoi[g] = 1'b1;
    end
    for (int n = 0; n < NL; n++) begin
      if (reg_wr_en) begin
        unique case (field_of(reg_addr, INTX_BANK_BASE, n))
          FLD_STAT: intx_w1c[n] = reg_wdata[0];
          FLD_SET:  intx_set[n] = reg_wdata[0];
          FLD_CLR:  intx_clr[n] = reg_wdata[0];
          default:  ;
        endcase
      end
      if (eoi_wr && reg_wdata == REG_DW'(n)) intx_eoi[n] = 1'b1;
    end
  end

  // read mux: both enable aliases return the mask
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NG; g++) begin
      unique case (field_of(reg_addr, MSI_BANK_BASE, g))
        FLD_STAT:         rd_mux = REG_DW'(msi_stat[g]);
        FLD_SET, FLD_CLR: rd_mux = REG_DW'(msi_en[g]);
        default:          ;
      endcase
    end
    for (int n = 0; n < NL; n++) begin
      unique case (field_of(reg_addr, INTX_BANK_BASE, n))
        FLD_STAT:         rd_mux = REG_DW'(intx_stat[n]);
        FLD_SET, FLD_CLR: rd_mux = REG_DW'(intx_en[n]);
        default:          ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
  import msi_agg_pkg::*;
#(
  parameter int NG  = 8,
  parameter int BPG = 4,
  parameter int NL  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              db_valid,
  input  logic [31:0]       db_vector,
  input  logic [NL-1:0]     intx_in,
  output logic [NG-1:0]     msi_irq,
  output logic [NL-1:0]     intx_irq
);

  localparam int NUM_VEC = NG * BPG;

  logic [NG-1:0][BPG-1:0] msi_stat, msi_en;
  logic [NG-1:0][BPG-1:0] msi_w1c, msi_set, msi_clr;
  logic [NG-1:0][BPG-1:0] db_hit;
  logic [NG-1:0]          msi_eoi;
  logic [NL-1:0]          intx_stat, intx_en, intx_w1c, intx_set, intx_clr, intx_eoi;
  logic                   bus_db_valid;
  logic [31:0]            bus_db_vec;
  logic                   port_db_ok, bus_db_ok;

  msi_agg_regif #(.NG(NG), .BPG(BPG), .NL(NL)) u_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .msi_stat     (msi_stat),
    .msi_en       (msi_en),
    .intx_stat    (intx_stat),
    .intx_en      (intx_en),
    .msi_w1c      (msi_w1c),
    .msi_set      (msi_set),
    .msi_clr      (msi_clr),
    .msi_eoi      (msi_eoi),
    .intx_w1c     (intx_w1c),
    .intx_set     (intx_set),
    .intx_clr     (intx_clr),
    .intx_eoi     (intx_eoi),
    .bus_db_valid (bus_db_valid),
    .bus_db_vec   (bus_db_vec),
    .reg_rdata    (reg_rdata)
  );

  assign port_db_ok = db_valid && vec_ok(db_vector, NUM_VEC);
  assign bus_db_ok  = bus_db_valid && vec_ok(bus_db_vec, NUM_VEC);

  // one-hot doorbell decode; both sources may land in the same cycle
  always_comb begin
    db_hit = '0;
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < BPG; b++) begin
        if (port_db_ok && vec_group(db_vector, NG) == g && vec_bit(db_vector, NG) == b)
          db_hit[g][b] = 1'b1;
        if (bus_db_ok && vec_group(bus_db_vec, NG) == g && vec_bit(bus_db_vec, NG) == b)
          db_hit[g][b] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    msi_group_slice #(.BPG(BPG)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .db_hit  (db_hit[g]),
      .w1c     (msi_w1c[g]),
      .en_set  (msi_set[g]),
      .en_clr  (msi_clr[g]),
      .eoi_hit (msi_eoi[g]),
      .stat_o  (msi_stat[g]),
      .en_o    (msi_en[g]),
      .irq_o   (msi_irq[g])
    );
  end

  for (genvar n = 0; n < NL; n++) begin : g_intx
    intx_line_slice u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (intx_in[n]),
      .w1c     (intx_w1c[n]),
      .en_set  (intx_set[n]),
      .en_clr  (intx_clr[n]),
      .eoi_hit (intx_eoi[n]),
      .stat_o  (intx_stat[n]),
      .en_o    (intx_en[n]),
      .irq_o   (intx_irq[n])
    );
  end

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && !vec_ok(db_vector, NUM_VEC) && !reg_wr_en) |=> $stable(msi_stat)); // R3

endmodule

// File: tb/msi_irq_agg_tb.sv
module msi_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        db_valid = 1'b0;
  logic [31:0] db_vector = '0;
  logic [3:0]  intx_in = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] m_stat [8];
  logic [3:0] m_en   [8];
  logic       l_stat [4];
  logic       l_en   [4];

  always #2 clk = ~clk;

  msi_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .db_valid(db_valid), .db_vector(db_vector), .intx_in(intx_in),
    .msi_irq(msi_irq), .intx_irq(intx_irq)
  );

  function automatic logic [11:0] a_grp(int g, int ofs);
    return 12'(256 + g * 16 + ofs);
  endfunction
  function automatic logic [11:0] a_lin(int n, int ofs);
    return 12'(384 + n * 16 + ofs);
  endfunction
  function automatic logic [7:0] exp_msi();
    logic [7:0] r;
    for (int g = 0; g < 8; g++) r[g] = (m_stat[g] & m_en[g]) != 4'd0;
    return r;
  endfunction
  function automatic logic [3:0] exp_intx();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = l_stat[n] & l_en[n];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask
  task automatic ring(logic [31:0] v);
    @(negedge clk); db_valid = 1'b1; db_vector = v;
    @(negedge clk); db_valid = 1'b0;
  endtask
  task automatic model_ring(logic [31:0] v);
    if (v < 32) m_stat[v & 7][v >> 3] = 1'b1;
  endtask

  task automatic check_group(string req, int g);
    logic [31:0] d;
    rd(a_grp(g, 4), d);  chk(req, d, {28'd0, m_stat[g]});
    rd(a_grp(g, 8), d);  chk(req, d, {28'd0, m_en[g]});
    rd(a_grp(g, 12), d); chk(req, d, {28'd0, m_en[g]});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'h1A2B3C4D));
    for (int g = 0; g < 8; g++) begin m_stat[g] = 0; m_en[g] = 0; end
    for (int n = 0; n < 4; n++) begin l_stat[n] = 0; l_en[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk("R11 msi_irq", {24'd0, msi_irq}, 0);
    chk("R11 intx_irq", {28'd0, intx_irq}, 0);
    rd(a_grp(3, 4), d); chk("R11 status", d, 0);
    rd(12'h7F0, d);     chk("R11 unmapped", d, 0);

    // R1 mapping: vector 25 -> group 1 bit 3
    ring(25); model_ring(25);
    check_group("R1 vec25", 1);
    chk("R6 not enabled", {24'd0, msi_irq}, 0);
    wr(a_grp(1, 8), 32'h8); m_en[1] = 4'h8;
    chk("R6 enabled", {24'd0, msi_irq}, {24'd0, exp_msi()});

    // R2 bus doorbell
    wr(12'h054, 32'd14); model_ring(14);
    check_group("R2 bus doorbell", 6);

    // R3 out of range
    ring(32); ring(40); ring(32'hFFFF_FFFF);
    wr(12'h054, 32'd33);
    for (int g = 0; g < 8; g++) begin
      rd(a_grp(g, 4), d); chk("R3 ignored", d, {28'd0, m_stat[g]});
    end

    // R7 EOI blanking for group 1, group 6 unaffected
    wr(a_grp(6, 8), 32'hF); m_en[6] = 4'hF;
    wr(12'h050, 32'd5);
    chk("R7 blank", {24'd0, msi_irq}, {24'd0, exp_msi() & 8'hFD});
    @(negedge clk);
    chk("R7 re-eval", {24'd0, msi_irq}, {24'd0, exp_msi()});
    // R10 EOI beyond range has no effect
    wr(12'h050, 32'd12);
    chk("R10 eoi 12", {24'd0, msi_irq}, {24'd0, exp_msi()});

    // R8 collision: doorbell and W1C on vector 25 in the same cycle
    @(negedge clk);
    db_valid = 1'b1; db_vector = 25;
    reg_wr_en = 1'b1; reg_addr = a_grp(1, 4); reg_wdata = 32'h8;
    @(negedge clk); db_valid = 1'b0; reg_wr_en = 1'b0;
    check_group("R8 collide", 1);

    // R4 W1C and zero writes
    wr(a_grp(1, 4), 32'h0);
    check_group("R4 zero write", 1);
    wr(a_grp(1, 4), 32'h8); m_stat[1] = 0;
    check_group("R4 w1c", 1);

    // R5 set and clear in one cycle is not possible via one bus; clear path
    wr(a_grp(6, 12), 32'h5); m_en[6] = 4'hA;
    check_group("R5 clear", 6);

    // R12 rdata holds without rd_en
    rd(a_grp(6, 4), d);
    ring(6); model_ring(6);
    @(negedge clk);
    chk("R12 hold", reg_rdata, d);

    // R9 legacy
    @(negedge clk); intx_in = 4'b0100;
    @(negedge clk); intx_in = 4'b0000; l_stat[2] = 1;
    rd(a_lin(2, 4), d); chk("R9 latch", d, 1);
    chk("R9 off", {28'd0, intx_irq}, 0);
    wr(a_lin(2, 8), 1); l_en[2] = 1;
    chk("R9 irq", {28'd0, intx_irq}, {28'd0, exp_intx()});
    rd(a_lin(2, 12), d); chk("R9 enable alias", d, 1);
    wr(12'h050, 32'd2);
    chk("R10 intx blank", {28'd0, intx_irq}, 0);
    @(negedge clk);
    chk("R10 intx re-eval", {28'd0, intx_irq}, 4'b0100);
    wr(a_lin(2, 4), 1); l_stat[2] = 0;
    chk("R9 w1c", {28'd0, intx_irq}, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op, g;
      op = $urandom_range(0, 6);
      g  = $urandom_range(0, 7);
      v  = $urandom_range(0, 39);
      case (op)
        0: begin ring(v); model_ring(v); end
        1: begin wr(12'h054, v); model_ring(v); end
        2: begin d = $urandom_range(0, 15); wr(a_grp(g, 4), d); m_stat[g] &= ~d[3:0]; end
        3: begin d = $urandom_range(0, 15); wr(a_grp(g, 8), d); m_en[g] |= d[3:0]; end
        4: begin d = $urandom_range(0, 15); wr(a_grp(g, 12), d); m_en[g] &= ~d[3:0]; end
        5: begin
             d = $urandom_range(0, 15);
             @(negedge clk); intx_in = d[3:0];
             @(negedge clk); intx_in = 4'd0;
             for (int n = 0; n < 4; n++) if (d[n]) l_stat[n] = 1;
           end
        default: begin
             int n;
             n = g & 3;
             d = $urandom_range(0, 3);
             if (d == 0) begin wr(a_lin(n, 4), 1); l_stat[n] = 0; end
             else if (d == 1) begin wr(a_lin(n, 8), 1); l_en[n] = 1; end
             else begin wr(a_lin(n, 12), 1); l_en[n] = 0; end
           end
      endcase
      chk("R6 random irq", {24'd0, msi_irq}, {24'd0, exp_msi()});
      chk("R9 random intx", {28'd0, intx_irq}, {28'd0, exp_intx()});
      if (i % 4 == 0) check_group("R1 random", g);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule